// File: doc/BRIEF.md
# Bimodal effective address generator

This block forms the memory address that a simple processor uses for an operand, and it also narrows instruction fetch addresses. Each operand request carries a mode code, two register-file read values (a base and an index), a field taken from the instruction, and a step amount. From these the block computes either an effective address or an operand source. For the step modes it also computes the new base register value and writes it back. All results appear on registered outputs one clock after the request.

A single width input sets the active address width. When it is low, every generated address keeps 24 bits. When it is high, every generated address keeps 31 bits. All bits above the active width read as zero. The width applies to operand effective addresses, to base register writeback values and to fetch addresses. The internal arithmetic is 32 bits wide, and the result is narrowed after the arithmetic.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 0 (register) drives `opnd_src` to 0 and `opnd_val` to `base_val`. `ea_valid` and `wb_en` stay low.
- R2: Mode code 1 (immediate) drives `opnd_src` to 1 and `opnd_val` to `instr_field`. No address is produced.
- R3: Mode code 2 (absolute) produces `ea` = `instr_field` narrowed to the active width. It raises `ea_valid` and drives `opnd_src` to 2.
- R4: Mode code 3 (register indirect) produces `ea` = `base_val` narrowed to the active width. `opnd_src` is 2.
- R5: Mode codes 4 (pre-increment) and 5 (pre-decrement) compute base+step or base-step. The narrowed result is driven on both `ea` and `wb_val`, with `wb_en` high.
- R6: Mode codes 6 (post-increment) and 7 (post-decrement) drive `ea` = narrowed `base_val`. They drive `wb_val` = narrowed base+step or base-step, with `wb_en` high.
- R7: The step is the constant 4 when `step_sel` is 0. When `step_sel` is 1, the step is `instr_step` zero-extended.
- R8: Mode code 8 (indexed) produces `ea` = narrowed (`base_val` + `index_val` + `instr_field`), computed modulo 2^32.
- R9: Narrowing means the following. With `wide_mode` at 0, bits 31:24 are zero. With `wide_mode` at 1, bit 31 is zero. This applies to `ea`, `wb_val` and `fetch_addr`.
- R10: A `fetch_req` in one cycle gives `fetch_vld` high in the next cycle, with `fetch_addr` = narrowed `fetch_pc`. This path runs independently of the operand path.
- R11: All outputs are registered with one cycle of latency. `wb_en` is a single-cycle pulse for each request and coincides with `ea_valid`. A cycle without `req_valid` gives low strobes, zero values and `opnd_src` = 3.
- R12: Mode codes 9 to 15 raise `illegal` for one cycle. They hold `ea_valid` and `wb_en` low and drive `opnd_src` to 3.
- R13: While `rst` is high and afterwards, until the first request, all strobes are low, all values are zero and `opnd_src` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request strobe |
| mode | input | 4 | Addressing mode code |
| wide_mode | input | 1 | 0: 24-bit addresses, 1: 31-bit addresses |
| base_val | input | 32 | Base register read value |
| index_val | input | 32 | Index register read value |
| instr_field | input | 32 | Absolute address, immediate value or displacement |
| instr_step | input | 8 | Step amount carried in the instruction |
| step_sel | input | 1 | 0: fixed step of 4, 1: use instr_step |
| fetch_req | input | 1 | Instruction fetch address strobe |
| fetch_pc | input | 32 | Raw fetch address |
| ea_valid | output | 1 | Effective address valid |
| ea | output | 32 | Narrowed effective address |
| opnd_src | output | 2 | 0 register, 1 immediate, 2 memory, 3 none |
| opnd_val | output | 32 | Operand value for register and immediate modes |
| wb_en | output | 1 | Base register writeback strobe |
| wb_val | output | 32 | Narrowed new base register value |
| illegal | output | 1 | Unknown mode code seen |
| fetch_vld | output | 1 | Fetch address valid |
| fetch_addr | output | 32 | Narrowed fetch address |

## Verification
The assertions assume the following about the inputs:
- `wide_mode` is meaningful only in the cycle of a request.
- The outputs describe the request from the previous cycle.
- `rst` is held for at least one clock at start.

The stimulus meets these assumptions. It drives every input on the falling edge and leaves each input stable through the following rising edge. It raises reset before any request. The stimulus deliberately places carries and borrows across bit 24 and bit 31, so that the zero-fill rule is exercised on values whose unnarrowed sum would set those bits. The stimulus also mixes back-to-back requests, idle cycles and simultaneous fetch requests.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_REG     = 4'd0,
    AM_IMM     = 4'd1,
    AM_ABS     = 4'd2,
    AM_RIND    = 4'd3,
    AM_PREINC  = 4'd4,
    AM_PREDEC  = 4'd5,
    AM_POSTINC = 4'd6,
    AM_POSTDEC = 4'd7,
    AM_INDEX   = 4'd8
  } am_e;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  // which raw value becomes the effective address
  typedef enum logic [1:0] {
    EA_BASE  = 2'd0,
    EA_ADJ   = 2'd1,
    EA_FIELD = 2'd2,
    EA_SUM   = 2'd3
  } ea_sel_e;

  typedef struct packed {
    logic    legal;
    logic    mem;
    logic    wb;
    logic    dec;
    src_e    src;
    ea_sel_e ea_sel;
  } ctl_t;

endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output ctl_t              ctl
);

  always_comb begin
    ctl        = '0;
    ctl.legal  = 1'b1;
    ctl.src    = SRC_MEM;
    ctl.ea_sel = EA_BASE;
    case (mode)
      AM_REG: begin
        ctl.src = SRC_REG;
      end
      AM_IMM: begin
        ctl.src = SRC_IMM;
      end
      AM_ABS: begin
        ctl.mem    = 1'b1;
        ctl.ea_sel = EA_FIELD;
      end
      AM_RIND: begin
        ctl.mem = 1'b1;
      end
      AM_PREINC: begin
        ctl.mem    = 1'b1;
        ctl.wb     = 1'b1;
        ctl.ea_sel = EA_ADJ;
      end
      AM_PREDEC: begin
        ctl.mem    = 1'b1;
        ctl.wb     = 1'b1;
        ctl.dec    = 1'b1;
        ctl.ea_sel = EA_ADJ;
      end
      AM_POSTINC: begin
        ctl.mem = 1'b1;
        ctl.wb  = 1'b1;
      end
      AM_POSTDEC: begin
        ctl.mem = 1'b1;
        ctl.wb  = 1'b1;
        ctl.dec = 1'b1;
      end
      AM_INDEX: begin
        ctl.mem    = 1'b1;
        ctl.ea_sel = EA_SUM;
      end
      default: begin
        ctl.legal = 1'b0;
        ctl.src   = SRC_NONE;
      end
    endcase
  end

endmodule

// File: rtl/eag_arith.sv
module eag_arith #(
  parameter int DW       = 32,
  parameter int STEP_W   = 8,
  parameter int FIX_STEP = 4
) (
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     index_val,
  input  logic [DW-1:0]     instr_field,
  input  logic [STEP_W-1:0] instr_step,
  input  logic              step_sel,
  input  logic              dec,
  output logic [DW-1:0]     adj_val,
  output logic [DW-1:0]     sum_val
);

  localparam logic [DW-1:0] FIX_V = DW'(FIX_STEP);

  logic [DW-1:0] step_v;

  // R7: step source
  always_comb begin
    step_v = step_sel ? {{(DW-STEP_W){1'b0}}, instr_step} : FIX_V;
  end

  // base adjust for R5/R6
  always_comb begin
    adj_val = dec ? (base_val - step_v) : (base_val + step_v);
  end

  // R8: three-operand index sum, modulo 2^DW
  always_comb begin
    sum_val = base_val + index_val + instr_field;
  end

endmodule

// File: rtl/eag_width_mask.sv
module eag_width_mask #(
  parameter int DW       = 32,
  parameter int NARROW_W = 24,
  parameter int WIDE_W   = 31
) (
  input  logic          wide,
  input  logic [DW-1:0] addr_in,
  output logic [DW-1:0] addr_out
);

  localparam logic [DW-1:0] NARROW_M = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DW-1:0] WIDE_M   = {{(DW-WIDE_W){1'b0}}, {WIDE_W{1'b1}}};

  // R9: zero-fill above the active width
  always_comb begin
    addr_out = addr_in & (wide ? WIDE_M : NARROW_M);
  end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NARROW_W = 24,
  parameter int WIDE_W   = 31,
  parameter int STEP_W   = 8,
  parameter int FIX_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic              wide_mode,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     index_val,
  input  logic [DW-1:0]     instr_field,
  input  logic [STEP_W-1:0] instr_step,
  input  logic              step_sel,
  input  logic              fetch_req,
  input  logic [DW-1:0]     fetch_pc,
  output logic              ea_valid,
  output logic [DW-1:0]     ea,
  output logic [1:0]        opnd_src,
  output logic [DW-1:0]     opnd_val,
  output logic              wb_en,
  output logic [DW-1:0]     wb_val,
  output logic              illegal,
  output logic              fetch_vld,
  output logic [DW-1:0]     fetch_addr
);

  localparam int NCH   = 3;
  localparam int CH_EA = 0;
  localparam int CH_WB = 1;
  localparam int CH_FE = 2;

  ctl_t          ctl;
  logic [DW-1:0] adj_val;
  logic [DW-1:0] sum_val;
  logic [DW-1:0] ea_raw;
  logic [DW-1:0] raw_ch [NCH];
  logic [DW-1:0] msk_ch [NCH];

  logic          do_mem;
  logic          do_wb;
  logic          do_bad;

  logic          ea_valid_q;
  logic [DW-1:0] ea_q;
  src_e          src_q;
  logic [DW-1:0] opnd_q;
  logic          wb_en_q;
  logic [DW-1:0] wb_val_q;
  logic          illegal_q;
  logic          fetch_vld_q;
  logic [DW-1:0] fetch_addr_q;
  logic          wide_q;

  eag_decode u_decode (
    .mode (mode),
    .ctl  (ctl)
  );

  eag_arith #(
    .DW       (DW),
    .STEP_W   (STEP_W),
    .FIX_STEP (FIX_STEP)
  ) u_arith (
    .base_val    (base_val),
    .index_val   (index_val),
    .instr_field (instr_field),
    .instr_step  (instr_step),
    .step_sel    (step_sel),
    .dec         (ctl.dec),
    .adj_val     (adj_val),
    .sum_val     (sum_val)
  );

  always_comb begin
    case (ctl.ea_sel)
      EA_BASE:  ea_raw = base_val;
      EA_ADJ:   ea_raw = adj_val;
      EA_FIELD: ea_raw = instr_field;
      default:  ea_raw = sum_val;
    endcase
  end

  always_comb begin
    raw_ch[CH_EA] = ea_raw;
    raw_ch[CH_WB] = adj_val;
    raw_ch[CH_FE] = fetch_pc;
  end

  // one narrowing stage per address channel, all under the same width bit
  for (genvar g = 0; g < NCH; g++) begin : g_mask
    eag_width_mask #(
      .DW       (DW),
      .NARROW_W (NARROW_W),
      .WIDE_W   (WIDE_W)
    ) u_mask (
      .wide     (wide_mode),
      .addr_in  (raw_ch[g]),
      .addr_out (msk_ch[g])
    );
  end

  always_comb begin
    do_mem = req_valid && ctl.legal && ctl.mem;
    do_wb  = req_valid && ctl.legal && ctl.wb;
    do_bad = req_valid && !ctl.legal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid_q   <= 1'b0;
      ea_q         <= '0;
      src_q        <= SRC_NONE;
      opnd_q       <= '0;
      wb_en_q      <= 1'b0;
      wb_val_q     <= '0;
      illegal_q    <= 1'b0;
      fetch_vld_q  <= 1'b0;
      fetch_addr_q <= '0;
      wide_q       <= 1'b0;
    end else begin
      ea_valid_q   <= do_mem;
      ea_q         <= do_mem ? msk_ch[CH_EA] : '0;
      wb_en_q      <= do_wb;
      wb_val_q     <= do_wb ? msk_ch[CH_WB] : '0;
      illegal_q    <= do_bad;
      src_q        <= req_valid ? ctl.src : SRC_NONE;
      if (req_valid && ctl.src == SRC_REG)
        opnd_q <= base_val;
      else if (req_valid && ctl.src == SRC_IMM)
        opnd_q <= instr_field;
      else
        opnd_q <= '0;
      fetch_vld_q  <= fetch_req;
      fetch_addr_q <= fetch_req ? msk_ch[CH_FE] : '0;
      wide_q       <= wide_mode;
    end
  end

  assign ea_valid   = ea_valid_q;
  assign ea         = ea_q;
  assign opnd_src   = src_q;
  assign opnd_val   = opnd_q;
  assign wb_en      = wb_en_q;
  assign wb_val     = wb_val_q;
  assign illegal    = illegal_q;
  assign fetch_vld  = fetch_vld_q;
  assign fetch_addr = fetch_addr_q;

  // R11: writeback only travels with a valid address
  p_wb_with_ea_r11: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ea_valid);

  // R11: each writeback pulse answers a request one cycle earlier
  p_wb_after_req_r11: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(req_valid));

  // R12: illegal code leaves address and writeback quiet
  p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!ea_valid && !wb_en && opnd_src == SRC_NONE));

  // R9: narrow mode zero-fills the upper bits of address and writeback
  p_narrow_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && !wide_q) |-> (ea[DW-1:NARROW_W] == '0 && wb_val[DW-1:NARROW_W] == '0));

  // R9: wide mode clears everything above the wide width
  p_wide_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && wide_q) |-> (ea[DW-1:WIDE_W] == '0));

  // R10: fetch strobe follows a fetch request and is narrowed
  p_fetch_follow_r10: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |-> ($past(fetch_req) && fetch_addr[DW-1:WIDE_W] == '0));

  // R1: non-memory sources never carry an address
  p_no_ea_reg_r1: assert property (@(posedge clk) disable iff (rst)
    (opnd_src != SRC_MEM) |-> !ea_valid);

endmodule

// File: tb/eff_addr_gen_tb.sv
`timescale 1ns/1ps
module eff_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic        wide_mode = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [31:0] instr_field = '0;
  logic [7:0]  instr_step = '0;
  logic        step_sel = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_pc = '0;

  logic        ea_valid;
  logic [31:0] ea;
  logic [1:0]  opnd_src;
  logic [31:0] opnd_val;
  logic        wb_en;
  logic [31:0] wb_val;
  logic        illegal;
  logic        fetch_vld;
  logic [31:0] fetch_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  eff_addr_gen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
    .wide_mode(wide_mode), .base_val(base_val), .index_val(index_val),
    .instr_field(instr_field), .instr_step(instr_step), .step_sel(step_sel),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .ea_valid(ea_valid), .ea(ea), .opnd_src(opnd_src), .opnd_val(opnd_val),
    .wb_en(wb_en), .wb_val(wb_val), .illegal(illegal),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr)
  );

  function automatic logic [31:0] narrow(input bit w, input logic [31:0] a);
    return w ? (a & 32'h7FFF_FFFF) : (a & 32'h00FF_FFFF);
  endfunction

  function automatic string tag_of(input int md, input bit rq);
    if (!rq) return "R11";
    case (md)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8: return "R8";
      default: return "R12";
    endcase
  endfunction

  // expected values, queued for the next falling edge
  logic [31:0] exp_q[$];

  // compare the whole output set; called on a falling edge
  task automatic compare(input string tag, input bit e_eav, input logic [31:0] e_ea,
                         input logic [1:0] e_src, input logic [31:0] e_op,
                         input bit e_wb, input logic [31:0] e_wbv, input bit e_ill,
                         input bit e_fv, input logic [31:0] e_fa);
    logic [167:0] act, exp;
    act = {ea_valid, ea, opnd_src, opnd_val, wb_en, wb_val, illegal, fetch_vld, fetch_addr};
    exp = {e_eav, e_ea, e_src, e_op, e_wb, e_wbv, e_ill, e_fv, e_fa};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, then check at the next falling edge
  task automatic cyc(input string tag, input bit rq, input int md, input bit w,
                     input logic [31:0] b, input logic [31:0] ix, input logic [31:0] d,
                     input logic [7:0] st, input bit ss, input bit fr, input logic [31:0] pc);
    logic [31:0] s, e_ea, e_op, e_wbv, e_fa;
    bit e_eav, e_wb, e_ill, e_fv;
    logic [1:0] e_src;
    s = ss ? {24'd0, st} : 32'd4;
    e_eav = 0; e_ea = 0; e_op = 0; e_wb = 0; e_wbv = 0; e_ill = 0; e_src = 2'd3;
    if (rq) begin
      case (md)
        0: begin e_src = 0; e_op = b; end
        1: begin e_src = 1; e_op = d; end
        2: begin e_src = 2; e_eav = 1; e_ea = narrow(w, d); end
        3: begin e_src = 2; e_eav = 1; e_ea = narrow(w, b); end
        4: begin e_src = 2; e_eav = 1; e_wb = 1; e_ea = narrow(w, b + s); e_wbv = e_ea; end
        5: begin e_src = 2; e_eav = 1; e_wb = 1; e_ea = narrow(w, b - s); e_wbv = e_ea; end
        6: begin e_src = 2; e_eav = 1; e_wb = 1; e_ea = narrow(w, b); e_wbv = narrow(w, b + s); end
        7: begin e_src = 2; e_eav = 1; e_wb = 1; e_ea = narrow(w, b); e_wbv = narrow(w, b - s); end
        8: begin e_src = 2; e_eav = 1; e_ea = narrow(w, b + ix + d); end
        default: begin e_ill = 1; end
      endcase
    end
    e_fv = fr;
    e_fa = fr ? narrow(w, pc) : 32'd0;
    req_valid = rq; mode = md[3:0]; wide_mode = w; base_val = b; index_val = ix;
    instr_field = d; instr_step = st; step_sel = ss; fetch_req = fr; fetch_pc = pc;
    @(negedge clk);
    compare(tag, e_eav, e_ea, e_src, e_op, e_wb, e_wbv, e_ill, e_fv, e_fa);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 32'h1234_5678, 32'h1, 32'h2, 8'h3, 0, 0, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state while reset is held
    compare("R13", 0, 0, 2'd3, 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    idle("R13");

    cyc("R1", 1, 0, 0, 32'hDEAD_BEEF, 0, 32'h5, 8'h0, 0, 0, 0);
    cyc("R2", 1, 1, 1, 32'h1, 0, 32'hCAFE_F00D, 8'h0, 0, 0, 0);
    cyc("R3", 1, 2, 0, 0, 0, 32'hFF12_3456, 8'h0, 0, 0, 0);
    cyc("R3", 1, 2, 1, 0, 0, 32'hFF12_3456, 8'h0, 0, 0, 0);
    cyc("R4", 1, 3, 0, 32'hABCD_EF01, 0, 0, 8'h0, 0, 0, 0);
    // R5: carry across bit 24 with the fixed step
    cyc("R5", 1, 4, 0, 32'h00FF_FFFC, 0, 0, 8'h0, 0, 0, 0);
    cyc("R5", 1, 4, 1, 32'h00FF_FFFC, 0, 0, 8'h0, 0, 0, 0);
    // R5 and R7: borrow from zero with an instruction step
    cyc("R5", 1, 5, 0, 32'h0, 0, 0, 8'h10, 1, 0, 0);
    cyc("R5", 1, 5, 1, 32'h0, 0, 0, 8'h10, 1, 0, 0);
    cyc("R6", 1, 6, 0, 32'h00FF_FFFE, 0, 0, 8'h0, 0, 0, 0);
    cyc("R6", 1, 7, 1, 32'h8000_0002, 0, 0, 8'h0, 0, 0, 0);
    cyc("R7", 1, 6, 1, 32'h100, 0, 0, 8'hFF, 1, 0, 0);
    cyc("R7", 1, 7, 1, 32'h100, 0, 0, 8'hFF, 0, 0, 0);
    cyc("R8", 1, 8, 0, 32'h00F0_0000, 32'h0010_0000, 32'h0000_0010, 8'h0, 0, 0, 0);
    cyc("R8", 1, 8, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h2, 8'h0, 0, 0, 0);
    cyc("R9", 1, 3, 1, 32'hFFFF_FFFF, 0, 0, 8'h0, 0, 0, 0);
    cyc("R9", 1, 3, 0, 32'hFFFF_FFFF, 0, 0, 8'h0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 8'h0, 0, 1, 32'hFFFF_FFFF);
    cyc("R10", 1, 4, 1, 32'h10, 0, 0, 8'h0, 0, 1, 32'hFFFF_FFFF);
    cyc("R12", 1, 9, 0, 32'h40, 0, 32'h8, 8'h4, 1, 0, 0);
    cyc("R12", 1, 15, 1, 32'h40, 0, 32'h8, 8'h4, 0, 0, 0);
    // R11: writeback drops after a single cycle
    cyc("R11", 1, 6, 0, 32'h20, 0, 0, 8'h0, 0, 0, 0);
    idle("R11");

    for (int n = 0; n < 3000; n++) begin
      int md;
      bit rq;
      md = $urandom_range(0, 15);
      rq = ($urandom_range(0, 7) != 0);
      cyc(tag_of(md, rq), rq, md, 1'($urandom_range(0, 1)), $urandom, $urandom, $urandom,
          8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule